// File: doc/BRIEF.md
# Programmable-Flag and Offset Controller for a Synchronous FIFO

This block runs next to an external synchronous FIFO memory and supplies everything except the storage. It keeps the write and read addresses and the word count. It drives the memory's write strobe and read-fetch strobe. It produces the read-side and write-side status flags, an early-warning almost-empty flag and an almost-full flag, and an echo pulse that marks a fresh word on the data output. The data output register sits outside the block. It loads from the memory on the clock edge that samples `rd_fetch` high, so the word is visible in the following cycle.

While master reset is held, two strap inputs pick one default offset from a fixed table of four values. Both threshold registers receive that value. On the same reset, the multiplexed pin `mode_sdi` chooses the read behaviour: standard, where every word needs a read request, or fall-through, where the first word moves to the output by itself. After reset, `mode_sdi` becomes a serial data line. Firmware can clock 2×OFS_W bits through it to replace both thresholds.

Two state machines carry the behaviour. The offset loader has state `LD_AE_BITS`, which collects almost-empty bits. After the last of those bits (transition *ae_done*) it moves to `LD_AF_BITS`, which collects almost-full bits. After the last almost-full bit (transition *af_commit*) it writes both thresholds and returns to `LD_AE_BITS`. Reset forces `LD_AE_BITS`.

The read tracker is reset to `RD_STD` when the pin is 0, or to `RD_FW_VOID` when the pin is 1. `RD_STD` has no transitions. `RD_FW_VOID` moves to `RD_FW_HOLD` when a word is fetched (transition *fall_through*). `RD_FW_HOLD` returns to `RD_FW_VOID` when the output word is read and the memory is empty (transition *drained*). It stays in `RD_FW_HOLD` when a read is replaced by a new fetch (transition *refill*).

Top module: `pflag_ctrl`

## Requirements
- R1: With `fsel` sampled during reset, the default threshold is 7 for 00, 63 for 01, 127 for 10 and 1023 for 11, and both thresholds take that same value.
- R2: Master reset (`mrst_n` low, synchronous) clears both addresses and the word count and restores both thresholds to the strap default. The first cycle after release shows empty, no echo and addresses 0.
- R3: `mode_sdi` sampled during reset selects fall-through mode when 1 and standard mode when 0. Later activity on the pin does not change the mode.
- R4: In fall-through mode, a word written into an empty FIFO is fetched on the next edge with no read request, and `rd_flag` rises together with that word on the output.
- R5: `rd_flag` is the empty flag in standard mode (1 = no words). In fall-through mode it is the output-ready flag (1 = valid word on the output).
- R6: `wr_flag` is the full flag in standard mode (1 = DEPTH words stored). In fall-through mode it is the input-ready flag (1 = memory below DEPTH words).
- R7: `almost_empty` is 1 when occupancy ≤ almost-empty threshold. Occupancy is the memory count, plus one in fall-through mode when the output holds a valid word.
- R8: `almost_full` is 1 when free space ≤ almost-full threshold. Free space is capacity minus occupancy. Capacity is DEPTH in standard mode and DEPTH+1 in fall-through mode.
- R9: `echo_rd` is high for one cycle after an edge on which a read request was accepted and a new word was fetched onto the output.
- R10: Each cycle with `ser_wen` and `ser_strobe` both high shifts one bit of `mode_sdi`, MSB first. The almost-empty threshold comes first and the almost-full threshold second, OFS_W bits each. Strobes without `ser_wen` are ignored. Both thresholds change only on the edge that takes the final bit.
- R11: `wr_ack` is `wr_en` gated by memory not full. A standard-mode read is accepted only when not empty. Each address steps by one per strobe and wraps from DEPTH-1 to 0.
- R12: Words leave the output in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both read and write sides |
| mrst_n | input | 1 | Synchronous master reset, active low |
| fsel | input | 2 | Default-threshold straps, sampled in reset |
| mode_sdi | input | 1 | Read-mode strap in reset, serial data afterwards |
| ser_wen | input | 1 | Serial write enable |
| ser_strobe | input | 1 | One-cycle serial clock pulse |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_ack | output | 1 | Memory write strobe (request accepted) |
| wr_addr | output | $clog2(DEPTH) | Memory write address |
| rd_fetch | output | 1 | Memory read strobe; output register loads on this edge |
| rd_addr | output | $clog2(DEPTH) | Memory read address |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| echo_rd | output | 1 | Pulse marking a read that placed a new word on the output |

## Verification
The bench uses the default DEPTH of 2048, so the threshold width is 11 bits. This makes the largest strap default of 1023 reachable on both sides: it is crossed at 1024 stored words and again at 1025. Filling the memory to 2048 words, and to 2049 words counting the output word in fall-through mode, exercises the full and input-ready boundaries and the address wrap. An 11-bit threshold also allows a serial almost-full value of 2040, so the almost-full flag can be tested a few words away from empty.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic [0:0] {
        LD_AE_BITS,
        LD_AF_BITS
    } ld_state_t;

    typedef enum logic [1:0] {
        RD_STD,
        RD_FW_VOID,
        RD_FW_HOLD
    } rd_state_t;

    function automatic int unsigned strap_offset(input logic [1:0] sel);
        case (sel)
            2'b00:   return 7;
            2'b01:   return 63;
            2'b10:   return 127;
            default: return 1023;
        endcase
    endfunction

endpackage

// File: rtl/pflag_offset_loader.sv
module pflag_offset_loader
    import pflag_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [1:0]       fsel,
    input  logic             sdi,
    input  logic             ser_wen,
    input  logic             ser_strobe,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam int BC_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [BC_W-1:0] LAST_IDX = BC_W'(OFS_W - 1);

    ld_state_t        st;
    ld_state_t        st_nxt;
    logic [BC_W-1:0]  bit_cnt;
    logic [OFS_W-1:0] ae_shd;
    logic [OFS_W-1:0] af_shd;
    logic [OFS_W-1:0] strap_val;
    logic             take_bit;
    logic             last_bit;

    assign strap_val = OFS_W'(strap_offset(fsel));
    assign take_bit  = ser_wen & ser_strobe;
    assign last_bit  = take_bit && (bit_cnt == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!mrst_n) st <= LD_AE_BITS;
        else         st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            LD_AE_BITS: if (last_bit) st_nxt = LD_AF_BITS;   // ae_done
            LD_AF_BITS: if (last_bit) st_nxt = LD_AE_BITS;   // af_commit
            default:    st_nxt = LD_AE_BITS;
        endcase
    end

    // shift data and threshold registers
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            bit_cnt <= '0;
            ae_shd  <= '0;
            af_shd  <= '0;
            ae_ofs  <= strap_val;
            af_ofs  <= strap_val;
        end else if (take_bit) begin
            bit_cnt <= last_bit ? '0 : bit_cnt + BC_W'(1);
            unique case (st)
                LD_AE_BITS: ae_shd <= {ae_shd[OFS_W-2:0], sdi};
                LD_AF_BITS: begin
                    if (last_bit) begin
                        ae_ofs <= ae_shd;
                        af_ofs <= {af_shd[OFS_W-2:0], sdi};
                    end else begin
                        af_shd <= {af_shd[OFS_W-2:0], sdi};
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pflag_ptr_track.sv
module pflag_ptr_track
    import pflag_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              mode_pin,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_ack,
    output logic              rd_fetch,
    output logic              echo_rd,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  mem_cnt,
    output logic              fwft,
    output logic              out_valid
);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(DEPTH - 1);

    rd_state_t st;
    rd_state_t st_nxt;
    logic      rd_take;
    logic      mem_full;
    logic      mem_empty;

    assign mem_full  = (mem_cnt == CNT_FULL);
    assign mem_empty = (mem_cnt == '0);

    // state register: mode strap captured while reset is held
    always_ff @(posedge clk) begin
        if (!mrst_n) st <= mode_pin ? RD_FW_VOID : RD_STD;
        else         st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            RD_STD:     st_nxt = RD_STD;
            RD_FW_VOID: if (!mem_empty) st_nxt = RD_FW_HOLD;            // fall_through
            RD_FW_HOLD: if (rd_en && mem_empty) st_nxt = RD_FW_VOID;    // drained
            default:    st_nxt = RD_STD;
        endcase
    end

    // outputs of the read tracker
    always_comb begin
        wr_ack    = wr_en && !mem_full;
        fwft      = (st != RD_STD);
        out_valid = (st == RD_FW_HOLD);
        rd_take   = 1'b0;
        rd_fetch  = 1'b0;
        unique case (st)
            RD_STD: begin
                rd_take  = rd_en && !mem_empty;
                rd_fetch = rd_take;
            end
            RD_FW_VOID: rd_fetch = !mem_empty;
            RD_FW_HOLD: begin
                rd_take  = rd_en;
                rd_fetch = rd_en && !mem_empty;                         // refill
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            wr_addr <= '0;
            rd_addr <= '0;
            mem_cnt <= '0;
            echo_rd <= 1'b0;
        end else begin
            if (wr_ack)   wr_addr <= (wr_addr == ADDR_TOP) ? '0 : wr_addr + ADDR_W'(1);
            if (rd_fetch) rd_addr <= (rd_addr == ADDR_TOP) ? '0 : rd_addr + ADDR_W'(1);
            case ({wr_ack, rd_fetch})
                2'b10:   mem_cnt <= mem_cnt + CNT_W'(1);
                2'b01:   mem_cnt <= mem_cnt - CNT_W'(1);
                default: mem_cnt <= mem_cnt;
            endcase
            echo_rd <= rd_take && rd_fetch;
        end
    end

endmodule

// File: rtl/pflag_flag_gen.sv
module pflag_flag_gen #(
    parameter int DEPTH = 2048,
    parameter int OFS_W = 11,
    parameter int CNT_W = 12
) (
    input  logic             fwft,
    input  logic             out_valid,
    input  logic [CNT_W-1:0] mem_cnt,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             rd_flag,
    output logic             wr_flag,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam logic [CNT_W-1:0] CAP_MEM = CNT_W'(DEPTH);

    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] room;

    always_comb begin
        occ          = mem_cnt + CNT_W'(fwft & out_valid);
        cap          = CAP_MEM + CNT_W'(fwft);
        room         = cap - occ;
        almost_empty = (occ <= CNT_W'(ae_ofs));
        almost_full  = (room <= CNT_W'(af_ofs));
        rd_flag      = fwft ? out_valid : (mem_cnt == '0);
        wr_flag      = fwft ? (mem_cnt != CAP_MEM) : (mem_cnt == CAP_MEM);
    end

endmodule

// File: rtl/pflag_ctrl.sv
module pflag_ctrl
    import pflag_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     mrst_n,
    input  logic [1:0]               fsel,
    input  logic                     mode_sdi,
    input  logic                     ser_wen,
    input  logic                     ser_strobe,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic                     wr_ack,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic                     rd_fetch,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     rd_flag,
    output logic                     wr_flag,
    output logic                     almost_empty,
    output logic                     almost_full,
    output logic                     echo_rd
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int OFS_W  = ADDR_W;
    localparam int CNT_W  = $clog2(DEPTH + 2);

    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    logic [CNT_W-1:0] mem_cnt;
    logic             fwft;
    logic             out_valid;

    pflag_offset_loader #(.OFS_W(OFS_W)) u_loader (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .fsel       (fsel),
        .sdi        (mode_sdi),
        .ser_wen    (ser_wen),
        .ser_strobe (ser_strobe),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs)
    );

    pflag_ptr_track #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .mode_pin  (mode_sdi),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_ack    (wr_ack),
        .rd_fetch  (rd_fetch),
        .echo_rd   (echo_rd),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .mem_cnt   (mem_cnt),
        .fwft      (fwft),
        .out_valid (out_valid)
    );

    pflag_flag_gen #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_flags (
        .fwft         (fwft),
        .out_valid    (out_valid),
        .mem_cnt      (mem_cnt),
        .ae_ofs       (ae_ofs),
        .af_ofs       (af_ofs),
        .rd_flag      (rd_flag),
        .wr_flag      (wr_flag),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

endmodule

// File: rtl/pflag_ctrl_chk.sv
module pflag_ctrl_chk #(
    parameter int DEPTH = 2048
) (
    input logic                     clk,
    input logic                     mrst_n,
    input logic                     fwft,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic                     wr_ack,
    input logic [$clog2(DEPTH)-1:0] wr_addr,
    input logic                     rd_fetch,
    input logic [$clog2(DEPTH)-1:0] rd_addr,
    input logic                     rd_flag,
    input logic                     wr_flag,
    input logic                     almost_empty,
    input logic                     echo_rd
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(DEPTH - 1);

    p_reset_ptrs_r2: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (wr_addr == '0 && rd_addr == '0 && !echo_rd));

    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(fwft));

    p_std_fetch_r5: assert property (@(posedge clk) disable iff (!mrst_n)
        (rd_fetch && !fwft) |-> !rd_flag);

    p_empty_ae_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        (!fwft && rd_flag) |-> almost_empty);

    p_echo_cause_r9: assert property (@(posedge clk) disable iff (!mrst_n)
        echo_rd |-> $past(rd_fetch && rd_en));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!mrst_n)
        wr_ack |-> (wr_en && (fwft ? wr_flag : !wr_flag)));

    p_rd_step_r11: assert property (@(posedge clk) disable iff (!mrst_n)
        rd_fetch |=> (rd_addr == (($past(rd_addr) == ADDR_TOP) ? '0 : $past(rd_addr) + ADDR_W'(1))));

endmodule

bind pflag_ctrl pflag_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .mrst_n       (mrst_n),
    .fwft         (fwft),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wr_ack       (wr_ack),
    .wr_addr      (wr_addr),
    .rd_fetch     (rd_fetch),
    .rd_addr      (rd_addr),
    .rd_flag      (rd_flag),
    .wr_flag      (wr_flag),
    .almost_empty (almost_empty),
    .echo_rd      (echo_rd)
);

// File: tb/pflag_ctrl_bench.sv
module pflag_ctrl_bench;
    localparam int DEPTH = 2048;
    localparam int AW    = 11;
    localparam int OW    = 11;

    logic          clk = 1'b0;
    always #5 clk = ~clk;

    logic          mrst_n = 1'b0;
    logic [1:0]    fsel = 2'b00;
    logic          mode_sdi = 1'b0;
    logic          ser_wen = 1'b0;
    logic          ser_strobe = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_ack, rd_fetch, rd_flag, wr_flag, almost_empty, almost_full, echo_rd;
    logic [AW-1:0] wr_addr, rd_addr;

    pflag_ctrl #(.DEPTH(DEPTH)) u_pflag_ctrl (
        .clk(clk), .mrst_n(mrst_n), .fsel(fsel), .mode_sdi(mode_sdi),
        .ser_wen(ser_wen), .ser_strobe(ser_strobe), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ack(wr_ack), .wr_addr(wr_addr), .rd_fetch(rd_fetch), .rd_addr(rd_addr),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .almost_empty(almost_empty),
        .almost_full(almost_full), .echo_rd(echo_rd)
    );

    // external storage and output register driven by the block's strobes
    logic [15:0] din = '0;
    logic [15:0] dout = '0;
    logic [15:0] mem [DEPTH];
    always @(posedge clk) begin
        if (wr_ack)   mem[wr_addr] <= din;
        if (rd_fetch) dout <= mem[rd_addr];
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dflt(input int s);
        case (s)
            0:       return 7;
            1:       return 63;
            2:       return 127;
            default: return 1023;
        endcase
    endfunction

    // behavioural reference model
    int          m_cnt, m_wp, m_rp, m_ae, m_af, m_bits, m_sh;
    bit          m_fwft, m_ov, m_echo, m_init, m_dvalid;
    logic [15:0] m_dout;
    logic [15:0] q[$];

    always @(posedge clk) begin
        bit wacc, racc, fet;
        if (!mrst_n) begin
            m_fwft = mode_sdi; m_cnt = 0; m_ov = 0; m_wp = 0; m_rp = 0;
            m_ae = dflt(int'(fsel)); m_af = m_ae; m_bits = 0; m_sh = 0;
            m_echo = 0; m_dvalid = 0; q.delete();
        end else begin
            wacc = wr_en && (m_cnt < DEPTH);
            if (!m_fwft) begin
                racc = rd_en && (m_cnt > 0);
                fet  = racc;
            end else begin
                racc = rd_en && m_ov;
                fet  = (m_cnt > 0) && (!m_ov || racc);
            end
            m_echo = racc && fet;
            if (fet) begin
                m_dout = q.pop_front(); m_dvalid = 1; m_rp = (m_rp + 1) % DEPTH;
            end
            if (wacc) begin
                q.push_back(din); m_wp = (m_wp + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(wacc) - int'(fet);
            if (m_fwft) begin
                if (fet) m_ov = 1; else if (racc) m_ov = 0;
            end
            if (ser_wen && ser_strobe) begin
                m_sh = (m_sh << 1) | int'(mode_sdi);
                m_bits++;
                if (m_bits == 2 * OW) begin
                    m_ae = (m_sh >> OW) & ((1 << OW) - 1);
                    m_af = m_sh & ((1 << OW) - 1);
                    m_bits = 0; m_sh = 0;
                end
            end
        end
        m_init = 1;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        int occ, cap, e_fet;
        if (m_init && !done) begin
            occ   = m_cnt + int'(m_fwft && m_ov);
            cap   = DEPTH + int'(m_fwft);
            e_fet = m_fwft ? int'((m_cnt > 0) && (!m_ov || rd_en)) : int'(rd_en && (m_cnt > 0));
            check("R5 rd_flag",       int'(rd_flag),      m_fwft ? int'(m_ov) : int'(m_cnt == 0));
            check("R6 wr_flag",       int'(wr_flag),      m_fwft ? int'(m_cnt != DEPTH) : int'(m_cnt == DEPTH));
            check("R7 almost_empty",  int'(almost_empty), int'(occ <= m_ae));
            check("R8 almost_full",   int'(almost_full),  int'((cap - occ) <= m_af));
            check("R9 echo_rd",       int'(echo_rd),      int'(m_echo));
            check("R11 wr_ack",       int'(wr_ack),       int'(wr_en && (m_cnt < DEPTH)));
            check("R11 rd_fetch",     int'(rd_fetch),     e_fet);
            check("R11 wr_addr",      int'(wr_addr),      m_wp);
            check("R11 rd_addr",      int'(rd_addr),      m_rp);
            if (m_dvalid) check("R12 output order", int'(dout), int'(m_dout));
        end
    end

    // stimulus helpers
    task automatic step(input bit w, input bit r);
        @(posedge clk); #1;
        wr_en = w; rd_en = r; ser_wen = 0; ser_strobe = 0;
        din = din + 16'd1;
    endtask

    task automatic ser(input bit b, input bit wen, input bit stb);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; mode_sdi = b; ser_wen = wen; ser_strobe = stb;
    endtask

    task automatic do_reset(input int s, input bit m);
        @(posedge clk); #1;
        mrst_n = 0; fsel = 2'(s); mode_sdi = m;
        wr_en = 0; rd_en = 0; ser_wen = 0; ser_strobe = 0;
        repeat (3) @(posedge clk);
        #1;
        mrst_n = 1; mode_sdi = ~m;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R2 reset state
        do_reset(0, 0);
        @(negedge clk);
        check("R2 empty after reset", int'(rd_flag), 1);
        check("R2 not full after reset", int'(wr_flag), 0);
        check("R2 almost_empty after reset", int'(almost_empty), 1);
        check("R2 wr_addr after reset", int'(wr_addr), 0);
        check("R2 rd_addr after reset", int'(rd_addr), 0);
        check("R2 echo after reset", int'(echo_rd), 0);

        // R1 default table, crossing each almost-empty boundary
        for (int s = 0; s < 4; s++) begin
            do_reset(s, 0);
            repeat (dflt(s)) step(1, 0);
            step(0, 0);
            @(negedge clk);
            check("R1 almost_empty at default", int'(almost_empty), 1);
            step(1, 0);
            step(0, 0);
            @(negedge clk);
            check("R1 almost_empty above default", int'(almost_empty), 0);
            if (s == 3) begin
                check("R1 almost_full default 1023 at 1024 words", int'(almost_full), 0);
                step(1, 0);
                step(0, 0);
                @(negedge clk);
                check("R1 almost_full default 1023 at 1025 words", int'(almost_full), 1);
                repeat (DEPTH - 1025) step(1, 0);
                step(0, 0);
                @(negedge clk);
                check("R6 full flag at DEPTH", int'(wr_flag), 1);
                check("R8 almost_full at DEPTH", int'(almost_full), 1);
                step(1, 0);
                @(negedge clk);
                check("R11 no write ack when full", int'(wr_ack), 0);
                step(0, 1);
                step(0, 0);
                @(negedge clk);
                check("R9 echo after read", int'(echo_rd), 1);
                repeat (DEPTH) step(0, 1);
            end else begin
                step(0, 1);
                step(0, 0);
                @(negedge clk);
                check("R9 echo after read", int'(echo_rd), 1);
                repeat (dflt(s) + 1) step(0, 1);
            end
            step(0, 0);
            @(negedge clk);
            check("R5 empty after drain", int'(rd_flag), 1);
        end

        // R3: pin high after release leaves standard mode in place
        do_reset(0, 0);
        mode_sdi = 1;
        step(1, 0);
        step(0, 0);
        step(0, 0);
        @(negedge clk);
        check("R3 standard mode kept (rd_flag is empty flag)", int'(rd_flag), 0);

        // R4: fall-through mode
        do_reset(1, 1);
        step(1, 0);
        step(0, 0);
        @(negedge clk);
        check("R4 not yet ready after write edge", int'(rd_flag), 0);
        @(negedge clk);
        check("R4 word fell through", int'(rd_flag), 1);
        check("R4 echo stays low on fall-through", int'(echo_rd), 0);
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] & lfsr[2]);
        end
        repeat (DEPTH + 40) step(1, 0);
        step(0, 0);
        @(negedge clk);
        check("R6 input-ready low with memory full", int'(wr_flag), 0);
        check("R8 almost_full at DEPTH+1", int'(almost_full), 1);
        repeat (DEPTH + 2) step(0, 1);

        // R10: serial programming, ae=5 then af=2040
        do_reset(0, 0);
        repeat (6) step(1, 0);
        step(0, 0);
        begin
            logic [2*OW-1:0] word;
            word = {11'd5, 11'd2040};
            for (int b = 2 * OW - 1; b >= 1; b--) begin
                ser(word[b], 1, 1);
                ser(~word[b], 0, 1);
                ser(~word[b], 1, 0);
            end
            ser(1'b0, 0, 0);
            @(negedge clk);
            check("R10 threshold unchanged before final bit", int'(almost_empty), 1);
            ser(word[0], 1, 1);
            ser(1'b0, 0, 0);
            @(negedge clk);
            check("R10 almost_empty uses new threshold 5", int'(almost_empty), 0);
            check("R10 almost_full with free 2042", int'(almost_full), 0);
        end
        repeat (2) step(1, 0);
        step(0, 0);
        @(negedge clk);
        check("R10 almost_full with free 2040", int'(almost_full), 1);
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3], lfsr[4]);
        end
        step(0, 0);
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule